// File: doc/BRIEF.md
# Kick-Protected Watchdog Timer

This block is a watchdog timer that software drives through four byte-wide registers on a simple synchronous bus. The bus has a write strobe and a two-bit address, and read data follows the address in the same cycle. Software loads a period in whole seconds and turns the timer on. From then on it must write one magic byte to the kick register often enough to stop the count reaching zero. A prescaler divides the input clock into a one-second tick, and each tick takes one second off the remaining count.

When the count expires, the block can drive a fixed-length pulse on a system-reset output, on a separate timeout indication output, or on both. Each output has its own arm bit. A lock bit can be set but not cleared by software. Once lock is set the timer cannot be switched off, and only a hardware reset of the block clears lock. All control bits update together from the byte written, so software changes individual bits by read-modify-write.

Top module: `kick_watchdog`

## Requirements
- R1: After reset the control byte reads 0, the period reads DEF_PERIOD, the remaining count reads 0, and both outputs are low.
- R2: The bus addresses are 0 control, 1 period, 2 kick and 3 remaining count. In the control byte, bit 0 is run, bit 2 is lock, bit 6 arms the system-reset output and bit 7 arms the timeout output. Control bits 1, 3, 4 and 5 read 0. The kick address reads 0.
- R3: A control write that takes run from 0 to 1 loads the remaining count from the period, with a period of 0 loading 1. A control write with run set while already running leaves the count and the second phase unchanged.
- R4: While running with a nonzero count, the count falls by one every CLK_HZ clock cycles, counted from the load. It reaches 0 exactly period × CLK_HZ cycles after the load.
- R5: Writing 0x6B to the kick address while running reloads the count from the period and restarts the second phase. This also holds after expiry, and it wins over a tick in the same cycle. Any other value, or any kick while stopped, leaves the count unchanged.
- R6: A write to the period address always stores the byte. While running it also reloads the count and restarts the second phase, with 0 loading 1, so the count never becomes 0 through a period write. While stopped the count is not touched.
- R7: The lock bit can only be set by a write. While lock is set, run cannot be cleared and the count keeps falling. Only a hardware reset clears lock.
- R8: When the count steps from 1 to 0, the system-reset output goes high for exactly PULSE_LEN cycles if bit 6 is set, and the timeout output does the same if bit 7 is set. The rise happens in the cycle in which the count reads 0. The count then stays at 0.
- R9: Clearing run while unlocked freezes the count at its current value, and no expiry pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, same cycle |
| sys_rst_o | output | 1 | System-reset pulse on expiry |
| tmo_pin_o | output | 1 | Timeout indication pulse on expiry |

## Verification
The bench targets the cycle in which a magic kick lands on the same edge as the last tick. A design that gives the tick priority would fire a reset pulse instead of reloading. It also checks a repeated enable while running and a period write while running: a design that reloads on the repeated enable, or fails to reload on the period write, reads back a count that is off by one second. A zero period has to load a count of 1 rather than firing at once. Lock has to hold run against a write of 0, and software must not be able to clear it. A frozen count after disable must never expire. Random periods, arm masks and good and bad kicks at random instants are checked against counts and pulse windows computed from the load instant. A wrong prescaler length or a wrong pulse length therefore shows up as a count or output mismatch.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int REG_W = 8;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_PERIOD = 2'd1;
    localparam logic [1:0] ADDR_KICK   = 2'd2;
    localparam logic [1:0] ADDR_LEFT   = 2'd3;

    localparam logic [REG_W-1:0] KICK_MAGIC = 8'h6B;

    localparam int BIT_RUN  = 0;
    localparam int BIT_LOCK = 2;
    localparam int BIT_RST  = 6;
    localparam int BIT_PIN  = 7;

    localparam int NUM_OUT = 2;

    typedef struct packed {
        logic             run;
        logic             lock;
        logic             rst_arm;
        logic             pin_arm;
        logic [REG_W-1:0] period;
        logic [REG_W-1:0] left;
    } wd_state_t;

endpackage

// File: rtl/kwd_prescaler.sv
module kwd_prescaler #(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_HZ - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    assign tick = run && !restart && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (restart || !run) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/kwd_ctrl.sv
module kwd_ctrl
    import kwd_pkg::*;
#(
    parameter logic [REG_W-1:0] DEF_PERIOD = 8'd10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic             tick,
    output wd_state_t        st,
    output logic             reload,
    output logic             fire,
    output logic [REG_W-1:0] rdata
);
    wd_state_t d, q;

    logic             wr_ctrl, wr_period, wr_kick;
    logic             start, kick_ok, retime;
    logic [REG_W-1:0] load_val;

    always_comb begin
        d        = q;
        reload   = 1'b0;
        fire     = 1'b0;
        wr_ctrl   = bus_wr && (bus_addr == ADDR_CTRL);
        wr_period = bus_wr && (bus_addr == ADDR_PERIOD);
        wr_kick   = bus_wr && (bus_addr == ADDR_KICK);

        if (wr_ctrl) begin
            d.lock    = q.lock | bus_wdata[BIT_LOCK];
            d.run     = bus_wdata[BIT_RUN] | (q.lock & q.run);
            d.rst_arm = bus_wdata[BIT_RST];
            d.pin_arm = bus_wdata[BIT_PIN];
        end
        if (wr_period) begin
            d.period = bus_wdata;
        end

        load_val = (d.period == '0) ? REG_W'(1) : d.period;
        start    = d.run && !q.run;
        kick_ok  = wr_kick && (bus_wdata == KICK_MAGIC) && q.run;
        retime   = wr_period && q.run;
        reload   = start || (d.run && (kick_ok || retime));

        if (reload) begin
            d.left = load_val;
        end else if (tick && d.run && (q.left != '0)) begin
            d.left = q.left - 1'b1;
            fire   = (q.left == REG_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{run: 1'b0, lock: 1'b0, rst_arm: 1'b0, pin_arm: 1'b0,
                   period: DEF_PERIOD, left: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rdata = '0;
        case (bus_addr)
            ADDR_CTRL: begin
                rdata[BIT_RUN]  = q.run;
                rdata[BIT_LOCK] = q.lock;
                rdata[BIT_RST]  = q.rst_arm;
                rdata[BIT_PIN]  = q.pin_arm;
            end
            ADDR_PERIOD: rdata = q.period;
            ADDR_KICK:   rdata = '0;
            ADDR_LEFT:   rdata = q.left;
            default:     rdata = '0;
        endcase
    end

    assign st = q;
endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    localparam int CW = $clog2(PULSE_LEN + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (trig) begin
            cnt_d = CW'(PULSE_LEN);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign pulse = (cnt_q != '0);
endmodule

// File: rtl/kick_watchdog.sv
module kick_watchdog
    import kwd_pkg::*;
#(
    parameter int               CLK_HZ     = 50_000_000,
    parameter int               PULSE_LEN  = 16,
    parameter logic [REG_W-1:0] DEF_PERIOD = 8'd10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             sys_rst_o,
    output logic             tmo_pin_o
);
    wd_state_t          ctl_st;
    logic               tick, reload, fire;
    logic [NUM_OUT-1:0] arm_vec, pulse_vec;

    kwd_ctrl #(.DEF_PERIOD(DEF_PERIOD)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .tick     (tick),
        .st       (ctl_st),
        .reload   (reload),
        .fire     (fire),
        .rdata    (bus_rdata)
    );

    kwd_prescaler #(.CLK_HZ(CLK_HZ)) i_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctl_st.run && (ctl_st.left != '0)),
        .restart(reload),
        .tick   (tick)
    );

    assign arm_vec = {ctl_st.pin_arm, ctl_st.rst_arm};

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        kwd_pulse #(.PULSE_LEN(PULSE_LEN)) i_pulse (
            .clk  (clk),
            .rst_n(rst_n),
            .trig (fire && arm_vec[g]),
            .pulse(pulse_vec[g])
        );
    end

    assign sys_rst_o = pulse_vec[0];
    assign tmo_pin_o = pulse_vec[1];
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
    import kwd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic       sys_rst_o,
    input logic       tmo_pin_o,
    input wd_state_t  st
);
    // R7: lock is sticky
    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st.lock |=> st.lock);

    // R7: a locked, running timer stays running
    a_r7_run_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st.lock && st.run) |=> st.run);

    // R4: with no bus write, the count only holds or falls by one
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> (st.left == $past(st.left)) || (st.left == $past(st.left) - 8'd1));

    // R6: a period write while running never leaves a zero count
    a_r6_nonzero_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADDR_PERIOD) && st.run) |=> (st.left != '0));

    // R6: the period changes only through a bus write
    a_r6_period_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(st.period));

    // R8: the reset pulse starts only at expiry and only when armed
    a_r8_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> ((st.left == '0) && $past(st.rst_arm)));

    // R8: the timeout pin pulse starts only at expiry and only when armed
    a_r8_pin_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_pin_o) |-> ((st.left == '0) && $past(st.pin_arm)));
endmodule

bind kick_watchdog kwd_checker i_kwd_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .sys_rst_o(sys_rst_o),
    .tmo_pin_o(tmo_pin_o),
    .st       (ctl_st)
);

// File: tb/test_kick_watchdog.sv
module test_kick_watchdog;
    localparam int         HZ   = 8;
    localparam int         PL   = 16;
    localparam logic [7:0] DEFP = 8'd10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       sys_rst_o, tmo_pin_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    kick_watchdog #(.CLK_HZ(HZ), .PULSE_LEN(PL), .DEF_PERIOD(DEFP)) i_kick_watchdog (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sys_rst_o(sys_rst_o), .tmo_pin_o(tmo_pin_o)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    function automatic int eff(int p);
        return (p == 0) ? 1 : p;
    endfunction

    function automatic int exp_left(int p, int k);
        if (k >= eff(p) * HZ) return 0;
        return eff(p) - k / HZ;
    endfunction

    function automatic int exp_pulse(int p, int k, bit arm);
        return (arm && k >= eff(p) * HZ && k < eff(p) * HZ + PL) ? 1 : 0;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int v;
        int unsigned seed;
        seed = 32'h5EED;
        void'($urandom(seed));
        @(negedge clk);
        do_reset();

        // R1 reset state
        rd(2'd0, v); check("R1 ctrl", v, 0);
        rd(2'd1, v); check("R1 period", v, int'(DEFP));
        rd(2'd3, v); check("R1 left", v, 0);
        check("R1 sys_rst_o", int'(sys_rst_o), 0);
        check("R1 tmo_pin_o", int'(tmo_pin_o), 0);
        rd(2'd2, v); check("R2 kick reads 0", v, 0);

        // R2 control bit positions
        wr(2'd0, 8'hFB);
        rd(2'd0, v); check("R2 ctrl bits", v, 8'hC1);
        wr(2'd0, 8'h3A);
        rd(2'd0, v); check("R2 unused bits", v, 0);

        // R3 / R6 zero period loads one second
        wr(2'd1, 8'd0);
        rd(2'd1, v); check("R6 period stored", v, 0);
        wr(2'd0, 8'h01);
        rd(2'd3, v); check("R3 zero period loads 1", v, 1);
        idle(HZ - 1);
        rd(2'd3, v); check("R4 before tick", v, 1);
        idle(1);
        rd(2'd3, v); check("R4 expiry", v, 0);
        check("R8 disarmed rst", int'(sys_rst_o), 0);
        wr(2'd0, 8'h00);

        // R3 repeated enable keeps count; R6 period write reloads
        wr(2'd1, 8'd4);
        wr(2'd0, 8'h01);
        idle(10);
        wr(2'd0, 8'h01);
        rd(2'd3, v); check("R3 re-enable keeps count", v, exp_left(4, 11));
        wr(2'd1, 8'd3);
        idle(5);
        rd(2'd3, v); check("R6 period write reloads", v, exp_left(3, 5));
        wr(2'd0, 8'h00);

        // R5 kicks
        wr(2'd1, 8'd2);
        wr(2'd0, 8'h41);
        idle(10);
        wr(2'd2, 8'h6A);
        idle(4);
        rd(2'd3, v); check("R5 bad kick ignored", v, exp_left(2, 15));
        wr(2'd2, 8'h6B);          // lands on the same edge as the last tick
        idle(9);
        rd(2'd3, v); check("R5 magic kick reloads", v, exp_left(2, 9));
        check("R5 no pulse after kick", int'(sys_rst_o), 0);
        idle(6);
        check("R8 low before expiry", int'(sys_rst_o), 0);
        idle(1);
        check("R8 rst rises", int'(sys_rst_o), 1);
        check("R8 pin unarmed", int'(tmo_pin_o), 0);
        rd(2'd3, v); check("R8 left zero", v, 0);
        idle(15);
        check("R8 pulse last cycle", int'(sys_rst_o), 1);
        idle(1);
        check("R8 pulse ended", int'(sys_rst_o), 0);
        rd(2'd3, v); check("R8 stays zero", v, 0);
        wr(2'd2, 8'h6B);
        rd(2'd3, v); check("R5 kick after expiry", v, 2);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'd5);
        rd(2'd3, v); check("R6 stopped write no reload", v, 2);
        rd(2'd1, v); check("R6 period stored", v, 5);
        wr(2'd2, 8'h6B);
        rd(2'd3, v); check("R5 kick while stopped", v, 2);

        // R9 disable freezes
        wr(2'd1, 8'd3);
        wr(2'd0, 8'h81);
        idle(12);
        wr(2'd0, 8'h00);
        idle(40);
        rd(2'd3, v); check("R9 frozen count", v, exp_left(3, 12));
        check("R9 no pin pulse", int'(tmo_pin_o), 0);

        // R7 lock
        wr(2'd1, 8'd2);
        wr(2'd0, 8'h05);
        idle(3);
        wr(2'd0, 8'h00);
        rd(2'd0, v); check("R7 run held by lock", v, 8'h05);
        rd(2'd3, v); check("R7 count running", v, exp_left(2, 4));
        idle(12);
        rd(2'd3, v); check("R7 still counts", v, exp_left(2, 16));
        wr(2'd0, 8'hC1);
        rd(2'd0, v); check("R7 lock not clearable", v, 8'hC5);
        do_reset();
        rd(2'd0, v); check("R7 reset clears lock", v, 0);

        // R4 / R5 / R8 random runs
        for (int it = 0; it < 24; it++) begin
            int p, arms, mode, k, k1, k2, kv;
            wr(2'd0, 8'h00);
            idle(PL + 2);
            p    = int'($urandom_range(0, 5));
            arms = int'($urandom_range(0, 3));
            mode = int'($urandom_range(0, 2));
            wr(2'd1, 8'(p));
            wr(2'd0, {arms[1], arms[0], 6'b000001});
            k = 0;
            if (mode != 0) begin
                k1 = int'($urandom_range(0, eff(p) * HZ - 2));
                idle(k1);
                kv = (mode == 2) ? 8'h6B : int'($urandom_range(0, 255));
                if (mode != 2 && kv == 8'h6B) kv = 8'h6C;
                wr(2'd2, 8'(kv));
                k = (mode == 2) ? 0 : k1 + 1;
            end
            k2 = int'($urandom_range(0, eff(p) * HZ + PL + 4));
            idle(k2);
            k = k + k2;
            rd(2'd3, v); check("R4 random left", v, exp_left(p, k));
            check("R8 random rst", int'(sys_rst_o), exp_pulse(p, k, arms[0]));
            check("R8 random pin", int'(tmo_pin_o), exp_pulse(p, k, arms[1]));
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule